// File: doc/BRIEF.md
# Hardware Cursor Overlay Fetcher

This block draws a small hardware cursor sprite over the live raster. Its settings are written through an indexed byte-wide register port: the cursor position, the bitmap base address, the line stride, the load mode and an enable bit. Each bitmap pixel is a 2-bit code.

When horizontal blanking begins, the block looks at the line that comes next. If that line crosses the cursor, the block reads that line's bitmap bytes from video memory over a request/acknowledge byte handshake and stores them in a line buffer. During the visible line it compares the raster X against the cursor window. For every covered pixel it drives a cursor-active flag and the pixel's 2-bit code. The display path never waits on memory.

Two skip registers let the cursor start partway into its bitmap. The cursor can then be clipped at the top or left screen edge. Colour lookup and pixel mixing are handled downstream.

Top module: `hw_cursor_overlay`

## Requirements
- R1: After reset `cursorActive` is low, `cursorPix` is 00 and `fetchReq` is low.
- R2: A write with `regWe` high stores `regWData` into the register chosen by `regIdx`:
  - 0/1: X position low/high byte.
  - 2/3: Y position low/high byte.
  - 4: horizontal skip.
  - 5: vertical skip.
  - 6/7/8: base address bits 7:0, 15:8 and 23:16.
  - 9: stride code.
  - 10: load mode.
  - 11: control, where bit 7 is the enable.
- R3: A rising edge of `hBlank` starts a line fetch only when the cursor is enabled and the next line N = rasterY+1 satisfies Y <= N <= Y + 64 - vSkip - 1. Otherwise no request is issued.
- R4: Fetch byte k of a line reads address B + row*stride + k. Here row = N - Y + vSkip. B is the base address in planar mode (`packedMode` low) and base*4 in packed mode.
- R5: Stride code 4 selects a 32-byte map line, and any other code selects 16 bytes. With load mode other than 2, exactly stride bytes are fetched per line.
- R6: With load mode 2 only even bytes are fetched (offset 2k instead of k), and only stride/2 of them. `fetchReq` stays high with a stable `fetchAddr` until `fetchAck`.
- R7: With control bit 7 clear, `cursorActive` stays low and no fetch is started.
- R8: The bitmap column is col = rasterX - X + hSkip. Its code sits in buffered byte col/4, at bits [7-2*(col%4) -: 2], so the most significant pair comes first.
- R9: The bitmap width is W = 4 * bytes fetched per line. A pixel can be shown only while X <= rasterX <= X + W - hSkip - 1.
- R10: Code 00 is transparent: `cursorActive` is low and `cursorPix` is 00. Any other code in the window gives `cursorActive` high and that code on `cursorPix`.
- R11: A blanking edge whose next line misses the cursor clears the buffered line, so nothing is shown on that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regIdx | input | 4 | Register index |
| regWData | input | 8 | Register write data |
| packedMode | input | 1 | Base address counts 32-bit words when high |
| rasterX | input | 16 | Current raster column |
| rasterY | input | 16 | Current raster line |
| hBlank | input | 1 | Horizontal blanking |
| fetchReq | output | 1 | Bitmap byte request |
| fetchAddr | output | 26 | Bitmap byte address |
| fetchAck | input | 1 | Request accepted, data valid |
| fetchData | input | 8 | Bitmap byte |
| cursorActive | output | 1 | Cursor pixel covers this raster pixel |
| cursorPix | output | 2 | Cursor pixel code |

## Verification
A wrong row or stride in the fetch sequencer shows up at once on `fetchAddr`, within the first request after the blanking edge. A wrong byte count shows up as extra or missing acknowledged requests before blanking ends. A stale buffer, a wrong valid flag or a wrong window comparison only shows during the following visible line, as a misplaced or missing `cursorActive` pixel. The bench therefore sweeps every column across and around the window right after each fetch.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
  localparam int BUF_BYTES = 32;
  localparam int BUF_IDX_W = $clog2(BUF_BYTES);
  localparam logic [7:0] STRIDE_WIDE_CODE = 8'd4;
  localparam logic [7:0] EVEN_LOAD_CODE = 8'd2;

  typedef struct packed {
    logic [15:0] xPos;
    logic [15:0] yPos;
    logic [7:0]  hSkip;
    logic [7:0]  vSkip;
    logic [23:0] base;
    logic [7:0]  strideCode;
    logic [7:0]  loadMode;
    logic        enable;
  } curCfg_t;

  typedef struct packed {
    logic                 lineStart;
    logic                 byteWr;
    logic                 lineDone;
    logic [BUF_IDX_W-1:0] byteIdx;
  } curStrobe_t;

  function automatic logic [5:0] strideBytes(curCfg_t c);
    return (c.strideCode == STRIDE_WIDE_CODE) ? 6'd32 : 6'd16;
  endfunction

  function automatic logic evenOnly(curCfg_t c);
    return c.loadMode == EVEN_LOAD_CODE;
  endfunction

  function automatic logic [5:0] lineBytes(curCfg_t c);
    return evenOnly(c) ? (strideBytes(c) >> 1) : strideBytes(c);
  endfunction
endpackage

// File: rtl/cursor_ctrl.sv
module cursor_ctrl
  import cursor_pkg::*;
#(
  parameter int MAP_LINES = 64,
  parameter int ADDR_W    = 26
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [3:0]        regIdx,
  input  logic [7:0]        regWData,
  input  logic              packedMode,
  input  logic [15:0]       rasterY,
  input  logic              hBlank,
  output logic              fetchReq,
  output logic [ADDR_W-1:0] fetchAddr,
  input  logic              fetchAck,
  output curCfg_t           cfg,
  output curStrobe_t        strobe
);
  localparam int ROW_W = $clog2(MAP_LINES);

  typedef enum logic {IDLE, FETCH} state_t;

  curCfg_t              cfgQ;
  state_t               state;
  logic                 hBlankQ;
  logic [BUF_IDX_W-1:0] idx;
  logic [ROW_W-1:0]     rowQ;
  logic                 rise, vHit, fetchStart;
  logic [15:0]          nextY, visRows;
  logic [16:0]          dy;
  logic [ROW_W-1:0]     rowNext;
  logic [BUF_IDX_W-1:0] lastIdx;
  logic [ADDR_W-1:0]    byteOff, baseEff;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgQ <= '0;
    else if (regWe) begin
      case (regIdx)
        4'd0:  cfgQ.xPos[7:0]    <= regWData;
        4'd1:  cfgQ.xPos[15:8]   <= regWData;
        4'd2:  cfgQ.yPos[7:0]    <= regWData;
        4'd3:  cfgQ.yPos[15:8]   <= regWData;
        4'd4:  cfgQ.hSkip        <= regWData;
        4'd5:  cfgQ.vSkip        <= regWData;
        4'd6:  cfgQ.base[7:0]    <= regWData;
        4'd7:  cfgQ.base[15:8]   <= regWData;
        4'd8:  cfgQ.base[23:16]  <= regWData;
        4'd9:  cfgQ.strideCode   <= regWData;
        4'd10: cfgQ.loadMode     <= regWData;
        4'd11: cfgQ.enable       <= regWData[7];
        default: ;
      endcase
    end
  end
  assign cfg = cfgQ;

  always_comb begin
    rise       = hBlank && !hBlankQ;
    nextY      = rasterY + 16'd1;
    dy         = {1'b0, nextY} - {1'b0, cfgQ.yPos};
    visRows    = (16'(cfgQ.vSkip) < 16'(MAP_LINES)) ? 16'(MAP_LINES) - 16'(cfgQ.vSkip) : 16'd0;
    vHit       = !dy[16] && (dy[15:0] < visRows);
    rowNext    = ROW_W'(dy[15:0] + 16'(cfgQ.vSkip));
    fetchStart = rise && cfgQ.enable && vHit;
    lastIdx    = BUF_IDX_W'(lineBytes(cfgQ) - 6'd1);
    baseEff    = packedMode ? ADDR_W'({cfgQ.base, 2'b00}) : ADDR_W'(cfgQ.base);
    byteOff    = ADDR_W'(rowQ) * ADDR_W'(strideBytes(cfgQ))
               + (evenOnly(cfgQ) ? ADDR_W'({idx, 1'b0}) : ADDR_W'(idx));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hBlankQ <= 1'b0;
      state   <= IDLE;
      idx     <= '0;
      rowQ    <= '0;
    end else begin
      hBlankQ <= hBlank;
      case (state)
        IDLE: if (fetchStart) begin
          state <= FETCH;
          idx   <= '0;
          rowQ  <= rowNext;
        end
        FETCH: if (fetchAck) begin
          if (idx == lastIdx) state <= IDLE;
          else idx <= idx + 1'b1;
        end
        default: state <= IDLE;
      endcase
    end
  end

  assign fetchReq         = (state == FETCH);
  assign fetchAddr        = baseEff + byteOff;
  assign strobe.lineStart = rise;
  assign strobe.byteWr    = fetchReq && fetchAck;
  assign strobe.byteIdx   = idx;
  assign strobe.lineDone  = fetchReq && fetchAck && (idx == lastIdx);

  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (fetchReq && !fetchAck && !regWe) |=> (fetchReq && $stable(fetchAddr)));

  p_req_needs_enable_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fetchReq) |-> $past(cfgQ.enable));
endmodule

// File: rtl/cursor_datapath.sv
module cursor_datapath
  import cursor_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  curCfg_t     cfg,
  input  curStrobe_t  strobe,
  input  logic [7:0]  fetchData,
  input  logic [15:0] rasterX,
  output logic        cursorActive,
  output logic [1:0]  cursorPix
);
  logic [7:0]  lineBuf [BUF_BYTES];
  logic        lineValid;
  logic [7:0]  linePix, visW, col, selByte;
  logic [16:0] dx;
  logic        inWin, show;
  logic [1:0]  pix;

  always_ff @(posedge clk) begin
    if (strobe.byteWr) lineBuf[strobe.byteIdx] <= fetchData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lineValid <= 1'b0;
    else if (strobe.lineDone) lineValid <= 1'b1;
    else if (strobe.lineStart) lineValid <= 1'b0;
  end

  always_comb begin
    linePix = {lineBytes(cfg), 2'b00};
    visW    = (cfg.hSkip < linePix) ? linePix - cfg.hSkip : 8'd0;
    dx      = {1'b0, rasterX} - {1'b0, cfg.xPos};
    inWin   = !dx[16] && (dx[15:0] < 16'(visW));
    col     = dx[7:0] + cfg.hSkip;
    selByte = lineBuf[col[BUF_IDX_W+1:2]];
    case (col[1:0])
      2'd0:    pix = selByte[7:6];
      2'd1:    pix = selByte[5:4];
      2'd2:    pix = selByte[3:2];
      default: pix = selByte[1:0];
    endcase
    show         = cfg.enable && lineValid && inWin;
    cursorPix    = show ? pix : 2'b00;
    cursorActive = show && (pix != 2'b00);
  end

  p_off_disabled_r7: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.enable |-> !cursorActive);

  p_active_code_r10: assert property (@(posedge clk) disable iff (!rstN)
    cursorActive |-> (cursorPix != 2'b00));

  p_left_edge_r9: assert property (@(posedge clk) disable iff (!rstN)
    cursorActive |-> (rasterX >= cfg.xPos));
endmodule

// File: rtl/hw_cursor_overlay.sv
module hw_cursor_overlay
  import cursor_pkg::*;
#(
  parameter int MAP_LINES = 64,
  parameter int ADDR_W    = 26
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [3:0]        regIdx,
  input  logic [7:0]        regWData,
  input  logic              packedMode,
  input  logic [15:0]       rasterX,
  input  logic [15:0]       rasterY,
  input  logic              hBlank,
  output logic              fetchReq,
  output logic [ADDR_W-1:0] fetchAddr,
  input  logic              fetchAck,
  input  logic [7:0]        fetchData,
  output logic              cursorActive,
  output logic [1:0]        cursorPix
);
  curCfg_t    cfg;
  curStrobe_t strobe;

  cursor_ctrl #(.MAP_LINES(MAP_LINES), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regIdx(regIdx), .regWData(regWData),
    .packedMode(packedMode), .rasterY(rasterY), .hBlank(hBlank),
    .fetchReq(fetchReq), .fetchAddr(fetchAddr), .fetchAck(fetchAck),
    .cfg(cfg), .strobe(strobe)
  );

  cursor_datapath uData (
    .clk(clk), .rstN(rstN), .cfg(cfg), .strobe(strobe), .fetchData(fetchData),
    .rasterX(rasterX), .cursorActive(cursorActive), .cursorPix(cursorPix)
  );
endmodule

// File: tb/tb_hw_cursor_overlay.sv
module tb_hw_cursor_overlay;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [3:0]  regIdx = '0;
  logic [7:0]  regWData = '0;
  logic        packedMode = 1'b0;
  logic [15:0] rasterX = '0;
  logic [15:0] rasterY = '0;
  logic        hBlank = 1'b0;
  logic        fetchReq;
  logic [25:0] fetchAddr;
  logic        fetchAck = 1'b0;
  logic [7:0]  fetchData = '0;
  logic        cursorActive;
  logic [1:0]  cursorPix;

  int nChecks = 0;
  int nFails  = 0;
  logic [25:0] fetchLog [64];
  int fetchCnt = 0;

  int mX, mY, mH, mV, mBase, mStride, mMode, mEn, mPacked;
  int lineHit, lineRow;

  always #10 clk = ~clk;

  hw_cursor_overlay dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regIdx(regIdx), .regWData(regWData),
    .packedMode(packedMode), .rasterX(rasterX), .rasterY(rasterY), .hBlank(hBlank),
    .fetchReq(fetchReq), .fetchAddr(fetchAddr), .fetchAck(fetchAck),
    .fetchData(fetchData), .cursorActive(cursorActive), .cursorPix(cursorPix)
  );

  function automatic logic [7:0] memByte(input logic [25:0] a);
    return (a[7:0] * 8'd37) ^ {a[11:8], a[15:12]} ^ 8'h96;
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      if (fetchAck) fetchAck = 1'b0;
      else if (fetchReq) begin
        fetchAck  = 1'b1;
        fetchData = memByte(fetchAddr);
        if (fetchCnt < 64) fetchLog[fetchCnt] = fetchAddr;
        fetchCnt++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input int data);
    @(negedge clk);
    regWe = 1'b1; regIdx = 4'(idx); regWData = 8'(data);
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic setCursor(input int x, input int y, input int h, input int v,
                           input int base, input int strideCode, input int mode,
                           input int en, input int pk);
    mX = x; mY = y; mH = h; mV = v; mBase = base;
    mStride = (strideCode == 4) ? 32 : 16; mMode = mode; mEn = en; mPacked = pk;
    wr(0, x & 255); wr(1, x >> 8); wr(2, y & 255); wr(3, y >> 8);
    wr(4, h); wr(5, v);
    wr(6, base & 255); wr(7, (base >> 8) & 255); wr(8, (base >> 16) & 255);
    wr(9, strideCode); wr(10, mode); wr(11, en ? 8'h80 : 8'h00);
    packedMode = pk[0];
  endtask

  function automatic int bytesPerLine();
    return (mMode == 2) ? mStride / 2 : mStride;
  endfunction

  function automatic logic [25:0] expAddr(input int row, input int k);
    int b;
    b = mPacked ? mBase * 4 : mBase;
    return 26'(b + row * mStride + ((mMode == 2) ? 2 * k : k));
  endfunction

  // Blanking edge before line y+1; checks request count and addresses (R3 R4 R5 R6).
  task automatic doLine(input int y, input string req);
    int n, nextY;
    nextY = y + 1;
    lineHit = (mEn != 0) && nextY >= mY && nextY < mY + 64 - mV;
    lineRow = nextY - mY + mV;
    n = lineHit ? bytesPerLine() : 0;
    @(negedge clk);
    rasterY = 16'(y);
    fetchCnt = 0;
    hBlank = 1'b1;
    repeat (150) @(negedge clk);
    hBlank = 1'b0;
    check({req, " fetch count"}, fetchCnt, n);
    for (int k = 0; k < n && k < 64; k++)
      check({req, " fetch address"}, int'(fetchLog[k]), int'(expAddr(lineRow, k)));
    check({req, " req idle after line"}, int'(fetchReq), 0);
  endtask

  // Sweep the displayed line (R8 R9 R10).
  task automatic sweep(input string req);
    int w, dx, col, code, b, expAct, expPix;
    w = bytesPerLine() * 4;
    rasterY = rasterY + 16'd1;
    for (int x = mX - 3; x < mX + w + 3; x++) begin
      @(negedge clk);
      rasterX = 16'(x);
      #2;
      dx = x - mX;
      expAct = 0; expPix = 0;
      if (lineHit != 0 && mEn != 0 && x >= mX && dx < w - mH) begin
        col  = dx + mH;
        b    = int'(memByte(expAddr(lineRow, col / 4)));
        code = (b >> (6 - 2 * (col % 4))) & 3;
        expPix = code;
        expAct = (code != 0);
      end
      check({req, " active"}, int'(cursorActive), expAct);
      check({req, " pixel code"}, int'(cursorPix), expPix);
    end
  endtask

  task automatic t_reset();
    check("R1 active at reset", int'(cursorActive), 0);
    check("R1 pix at reset", int'(cursorPix), 0);
    check("R1 req at reset", int'(fetchReq), 0);
  endtask

  task automatic t_basic();
    setCursor(16'h0105, 50, 0, 0, 24'h001000, 2, 1, 1, 0);
    doLine(49, "R2 R3 R4 R5 first line");
    sweep("R8 R9 R10 first line");
    doLine(60, "R4 row 11");
    sweep("R8 R10 row 11");
  endtask

  task automatic t_wide_packed();
    setCursor(40, 300, 0, 3, 24'h012345, 4, 1, 1, 1);
    doLine(304, "R4 R5 packed wide");
    sweep("R9 wide line");
  endtask

  task automatic t_even_skip();
    setCursor(200, 10, 5, 0, 24'h00ABC0, 2, 2, 1, 0);
    doLine(12, "R6 even bytes");
    sweep("R6 R8 R9 hSkip window");
  endtask

  task automatic t_edges();
    setCursor(30, 100, 0, 4, 24'h000200, 2, 1, 1, 0);
    doLine(98, "R3 above top");
    sweep("R11 missed line");
    doLine(158, "R3 last visible row");
    sweep("R8 last row");
    doLine(159, "R3 past bottom");
    sweep("R11 cleared after miss");
  endtask

  task automatic t_disable();
    setCursor(70, 20, 0, 0, 24'h000400, 2, 1, 1, 0);
    doLine(25, "R3 enabled line");
    wr(11, 8'h7F);
    mEn = 0;
    sweep("R7 disabled display");
    doLine(26, "R7 no fetch when disabled");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2;
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_basic();
    t_wide_packed();
    t_even_skip();
    t_edges();
    t_disable();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule